// File: doc/BRIEF.md
# Age-Ordered Packet Crossbar

This block is a packet crossbar between a set of requestors and a set of destinations. A requestor offers at most one packet per cycle. A packet has a destination index and a payload of one or two beats. Each requestor-destination pair has its own two-entry queue. A per-pair credit output tells the requestor whether that queue still has room. A request made while the credit is low is dropped.

A packet moves through three registered stages. The first stage writes it into its queue. The second stage is the grant, where one arbiter per destination picks a queue head and loads it into a grant register. The third stage drives the destination port. Each arbiter picks the head that has waited longest, measured with a free-running timestamp that is stored when the packet is queued. When two heads have the same age, the lower requestor index wins. A two-beat packet holds its destination for two consecutive cycles. The first cycle carries the low half of the payload and the second carries the high half. No other grant is made to that destination until the second beat has gone out.

Top module: `xbar_oldest_first`

## Requirements
- R1: While reset is held and right after it, every `dstValid` bit is 0 and every `reqCredit` bit is 1.
- R2: A packet accepted at clock edge E with its destination idle appears on that destination port right after edge E+2. The port shows the requestor index on `dstSrc` and payload bits [BEATW-1:0] on `dstData`.
- R3: `reqCredit[r*NDST+d]` is 0 exactly when two packets from requestor r are waiting for destination d. A request made while that credit is 0 is dropped and is never delivered.
- R4: Among queue heads waiting for the same destination, the one queued at the earliest edge is granted first, whatever its requestor index.
- R5: Among heads queued at the same edge, the lower requestor index is granted first.
- R6: A packet with `reqTwoBeat`=1 shows its low half with `dstLast`=0 and then, on the very next cycle, its high half with `dstLast`=1 and the same `dstSrc`. No other packet is sent to that destination in between.
- R7: Each destination sends at most one beat per cycle. Different destinations move packets in the same cycle without affecting each other.
- R8: A single-beat packet (`reqTwoBeat`=0) shows `dstLast`=1 on its only beat, and the destination is free for a new grant on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | NREQ | One request strobe per requestor |
| reqDst | input | NREQ*DSTW | Destination index of each requestor's request |
| reqTwoBeat | input | NREQ | 1: the payload is sent as two beats |
| reqData | input | NREQ*2*BEATW | Payload of each request, low half first |
| reqCredit | output | NREQ*NDST | Queue room flag for each pair, at bit r*NDST+d |
| dstValid | output | NDST | A beat is present on the destination port |
| dstSrc | output | NDST*SRCW | Requestor index of the beat |
| dstData | output | NDST*BEATW | Beat payload |
| dstLast | output | NDST | Final beat of the packet |

## Verification
The bench builds the block with four requestors, two destinations, 8-bit beats and a 5-bit timestamp. The short timestamp wraps several times during the run, so the modular age comparison is exercised across a wrap. Four requestors firing two-beat packets at one destination fill queues to their credit limit within two cycles. That load makes the same-age ties, the dropped third requests and a long gap-free burst of beats all show up on the ports. With two destinations, a separate test shows that independent traffic proceeds in parallel.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int SRC_MAX_W = 8;

  typedef struct packed {
    logic                 take;
    logic [SRC_MAX_W-1:0] src;
  } grantStrobeT;
endpackage

// File: rtl/xbar_arb_ctrl.sv
module xbar_arb_ctrl
  import xbar_pkg::*;
#(
  parameter int NREQ = 4,
  parameter int NDST = 4,
  parameter int TSW  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              headValid [NREQ][NDST],
  input  logic [TSW-1:0]    headTs    [NREQ][NDST],
  input  logic              busy      [NDST],
  output logic [TSW-1:0]    tsNow,
  output grantStrobeT       strobe    [NDST]
);
  localparam int SRCW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [TSW-1:0] ageOf [NREQ][NDST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tsNow <= '0;
    else       tsNow <= tsNow + 1'b1;
  end

  always_comb begin
    for (int r = 0; r < NREQ; r++)
      for (int d = 0; d < NDST; d++)
        ageOf[r][d] = tsNow - headTs[r][d];
  end

  always_comb begin
    for (int d = 0; d < NDST; d++) begin
      logic           found;
      logic [TSW-1:0] bestAge;
      int             bestIdx;
      found   = 1'b0;
      bestAge = '0;
      bestIdx = 0;
      for (int r = 0; r < NREQ; r++) begin
        if (headValid[r][d] && (!found || ageOf[r][d] > bestAge)) begin
          found   = 1'b1;
          bestAge = ageOf[r][d];
          bestIdx = r;
        end
      end
      strobe[d].take = found && !busy[d];
      strobe[d].src  = SRC_MAX_W'(bestIdx);
    end
  end

  for (genvar gd = 0; gd < NDST; gd++) begin : g_chk_dst
    for (genvar gr = 0; gr < NREQ; gr++) begin : g_chk_req
      // R4
      oldest_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobe[gd].take && headValid[gr][gd]
          |-> ageOf[gr][gd] <= ageOf[strobe[gd].src[SRCW-1:0]][gd]);
      // R5
      tie_low_index_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobe[gd].take && headValid[gr][gd]
          && ageOf[gr][gd] == ageOf[strobe[gd].src[SRCW-1:0]][gd]
          |-> strobe[gd].src <= SRC_MAX_W'(gr));
    end
  end
endmodule

// File: rtl/xbar_queue_dp.sv
module xbar_queue_dp
  import xbar_pkg::*;
#(
  parameter int NREQ  = 4,
  parameter int NDST  = 4,
  parameter int BEATW = 16,
  parameter int TSW   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NREQ-1:0]            reqValid,
  input  logic [NREQ*((NDST > 1) ? $clog2(NDST) : 1)-1:0] reqDst,
  input  logic [NREQ-1:0]            reqTwoBeat,
  input  logic [NREQ*2*BEATW-1:0]    reqData,
  input  logic [TSW-1:0]             tsNow,
  input  grantStrobeT                strobe    [NDST],
  output logic                       headValid [NREQ][NDST],
  output logic [TSW-1:0]             headTs    [NREQ][NDST],
  output logic                       busy      [NDST],
  output logic [NREQ*NDST-1:0]       reqCredit,
  output logic [NDST-1:0]            dstValid,
  output logic [NDST*((NREQ > 1) ? $clog2(NREQ) : 1)-1:0] dstSrc,
  output logic [NDST*BEATW-1:0]      dstData,
  output logic [NDST-1:0]            dstLast
);
  localparam int DSTW = (NDST > 1) ? $clog2(NDST) : 1;
  localparam int SRCW = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int PW   = 2 * BEATW;

  logic [PW-1:0]   qData [NREQ][NDST][2];
  logic            qTwo  [NREQ][NDST][2];
  logic [TSW-1:0]  qTs   [NREQ][NDST][2];
  logic [1:0]      qCnt  [NREQ][NDST];
  logic            push  [NREQ][NDST];
  logic            pop   [NREQ][NDST];

  logic            gValid [NDST];
  logic [SRCW-1:0] gSrc   [NDST];
  logic [PW-1:0]   gData  [NDST];
  logic            gTwo   [NDST];
  logic            gBeat  [NDST];

  logic            txValid [NDST];
  logic [SRCW-1:0] txSrc   [NDST];
  logic [BEATW-1:0] txData [NDST];
  logic            txLast  [NDST];

  always_comb begin
    for (int r = 0; r < NREQ; r++)
      for (int d = 0; d < NDST; d++) begin
        push[r][d] = reqValid[r] && (reqDst[r*DSTW +: DSTW] == DSTW'(d))
                     && (qCnt[r][d] != 2'd2);
        pop[r][d]  = strobe[d].take && (strobe[d].src == SRC_MAX_W'(r));
        headValid[r][d]      = qCnt[r][d] != 2'd0;
        headTs[r][d]         = qTs[r][d][0];
        reqCredit[r*NDST+d]  = qCnt[r][d] != 2'd2;
      end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NREQ; r++)
        for (int d = 0; d < NDST; d++) qCnt[r][d] <= 2'd0;
    end else begin
      for (int r = 0; r < NREQ; r++)
        for (int d = 0; d < NDST; d++)
          qCnt[r][d] <= qCnt[r][d] + {1'b0, push[r][d]} - {1'b0, pop[r][d]};
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREQ; r++)
      for (int d = 0; d < NDST; d++) begin
        if (pop[r][d]) begin
          if (qCnt[r][d] == 2'd2) begin
            qData[r][d][0] <= qData[r][d][1];
            qTwo[r][d][0]  <= qTwo[r][d][1];
            qTs[r][d][0]   <= qTs[r][d][1];
          end else if (push[r][d]) begin
            qData[r][d][0] <= reqData[r*PW +: PW];
            qTwo[r][d][0]  <= reqTwoBeat[r];
            qTs[r][d][0]   <= tsNow;
          end
        end else if (push[r][d]) begin
          qData[r][d][qCnt[r][d][0]] <= reqData[r*PW +: PW];
          qTwo[r][d][qCnt[r][d][0]]  <= reqTwoBeat[r];
          qTs[r][d][qCnt[r][d][0]]   <= tsNow;
        end
      end
  end

  always_comb begin
    for (int d = 0; d < NDST; d++)
      busy[d] = gValid[d] && gTwo[d] && !gBeat[d];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int d = 0; d < NDST; d++) begin
        gValid[d]  <= 1'b0;
        gBeat[d]   <= 1'b0;
        gSrc[d]    <= '0;
        gData[d]   <= '0;
        gTwo[d]    <= 1'b0;
        txValid[d] <= 1'b0;
        txSrc[d]   <= '0;
        txData[d]  <= '0;
        txLast[d]  <= 1'b0;
      end
    end else begin
      for (int d = 0; d < NDST; d++) begin
        txValid[d] <= gValid[d];
        txSrc[d]   <= gSrc[d];
        txData[d]  <= gBeat[d] ? gData[d][PW-1:BEATW] : gData[d][BEATW-1:0];
        txLast[d]  <= !gTwo[d] || gBeat[d];
        if (busy[d]) begin
          gBeat[d] <= 1'b1;
        end else begin
          gValid[d] <= strobe[d].take;
          gBeat[d]  <= 1'b0;
          if (strobe[d].take) begin
            gSrc[d]  <= strobe[d].src[SRCW-1:0];
            gData[d] <= qData[strobe[d].src[SRCW-1:0]][d][0];
            gTwo[d]  <= qTwo[strobe[d].src[SRCW-1:0]][d][0];
          end
        end
      end
    end
  end

  always_comb begin
    for (int d = 0; d < NDST; d++) begin
      dstValid[d]                = txValid[d];
      dstSrc[d*SRCW +: SRCW]     = txSrc[d];
      dstData[d*BEATW +: BEATW]  = txData[d];
      dstLast[d]                 = txLast[d];
    end
  end

  for (genvar gd = 0; gd < NDST; gd++) begin : g_chk
    // R7
    grant_has_head_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe[gd].take |-> qCnt[strobe[gd].src[SRCW-1:0]][gd] != 2'd0);
    // R6
    second_beat_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
      txValid[gd] && !txLast[gd] |=> txValid[gd] && txLast[gd] && $stable(txSrc[gd]));
    // R2
    grant_to_transmit_chk: assert property (@(posedge clk) disable iff (!rstN)
      gValid[gd] |=> txValid[gd]);
  end
endmodule

// File: rtl/xbar_oldest_first.sv
module xbar_oldest_first
  import xbar_pkg::*;
#(
  parameter int NREQ  = 4,
  parameter int NDST  = 4,
  parameter int BEATW = 16,
  parameter int TSW   = 8,
  localparam int DSTW = (NDST > 1) ? $clog2(NDST) : 1,
  localparam int SRCW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NREQ-1:0]         reqValid,
  input  logic [NREQ*DSTW-1:0]    reqDst,
  input  logic [NREQ-1:0]         reqTwoBeat,
  input  logic [NREQ*2*BEATW-1:0] reqData,
  output logic [NREQ*NDST-1:0]    reqCredit,
  output logic [NDST-1:0]         dstValid,
  output logic [NDST*SRCW-1:0]    dstSrc,
  output logic [NDST*BEATW-1:0]   dstData,
  output logic [NDST-1:0]         dstLast
);
  logic           headValid [NREQ][NDST];
  logic [TSW-1:0] headTs    [NREQ][NDST];
  logic           busy      [NDST];
  logic [TSW-1:0] tsNow;
  grantStrobeT    strobe    [NDST];

  xbar_arb_ctrl #(.NREQ(NREQ), .NDST(NDST), .TSW(TSW)) uCtrl (
    .clk(clk), .rstN(rstN), .headValid(headValid), .headTs(headTs),
    .busy(busy), .tsNow(tsNow), .strobe(strobe)
  );

  xbar_queue_dp #(.NREQ(NREQ), .NDST(NDST), .BEATW(BEATW), .TSW(TSW)) uData (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqDst(reqDst),
    .reqTwoBeat(reqTwoBeat), .reqData(reqData), .tsNow(tsNow), .strobe(strobe),
    .headValid(headValid), .headTs(headTs), .busy(busy), .reqCredit(reqCredit),
    .dstValid(dstValid), .dstSrc(dstSrc), .dstData(dstData), .dstLast(dstLast)
  );
endmodule

// File: tb/tb_xbar_oldest_first.sv
module tb_xbar_oldest_first;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ = 4, NDST = 2, BEATW = 8, TSW = 5;
  localparam int DSTW = 1, SRCW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NREQ-1:0]         reqValid = '0;
  logic [NREQ*DSTW-1:0]    reqDst = '0;
  logic [NREQ-1:0]         reqTwoBeat = '0;
  logic [NREQ*2*BEATW-1:0] reqData = '0;
  logic [NREQ*NDST-1:0]    reqCredit;
  logic [NDST-1:0]         dstValid;
  logic [NDST*SRCW-1:0]    dstSrc;
  logic [NDST*BEATW-1:0]   dstData;
  logic [NDST-1:0]         dstLast;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbar_oldest_first #(.NREQ(NREQ), .NDST(NDST), .BEATW(BEATW), .TSW(TSW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqDst(reqDst),
    .reqTwoBeat(reqTwoBeat), .reqData(reqData), .reqCredit(reqCredit),
    .dstValid(dstValid), .dstSrc(dstSrc), .dstData(dstData), .dstLast(dstLast)
  );

  // {req[1:0], dst, twoBeat, payload[15:0]}
  localparam logic [19:0] VEC [6] = '{
    {2'd0, 1'b0, 1'b0, 16'h1234},
    {2'd3, 1'b1, 1'b0, 16'h00A5},
    {2'd1, 1'b0, 1'b1, 16'hBEEF},
    {2'd2, 1'b1, 1'b1, 16'h5AC3},
    {2'd3, 1'b0, 1'b1, 16'hFF00},
    {2'd1, 1'b1, 1'b0, 16'h7E81}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearReq();
    reqValid = '0; reqTwoBeat = '0; reqDst = '0; reqData = '0;
  endtask

  task automatic setReq(input int r, input int d, input bit two, input logic [15:0] data);
    reqValid[r] = 1'b1;
    reqDst[r*DSTW +: DSTW] = DSTW'(d);
    reqTwoBeat[r] = two;
    reqData[r*16 +: 16] = data;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int beatCnt;
    int firstSrc [9];
    int firstLow [9];
    int nFirst;
    int prevSrc;
    bit prevOpen;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(dstValid == '0, "R1 dstValid in reset", int'(dstValid), 0);
    check(reqCredit == '1, "R1 credit in reset", int'(reqCredit), 255);
    rstN = 1'b1;
    @(negedge clk);
    check(dstValid == '0 && reqCredit == '1, "R1 after reset", int'(reqCredit), 255);

    // R2, R6, R8: table of single packets
    for (int i = 0; i < 6; i++) begin
      int r, d; bit two; logic [15:0] pl;
      r = int'(VEC[i][19:18]); d = int'(VEC[i][17]); two = VEC[i][16]; pl = VEC[i][15:0];
      setReq(r, d, two, pl);
      @(negedge clk); clearReq();
      @(negedge clk);
      check(dstValid[d] == 1'b0, "R2 not before third stage", int'(dstValid[d]), 0);
      @(negedge clk);
      check(dstValid[d] == 1'b1, "R2 valid", int'(dstValid[d]), 1);
      check(int'(dstSrc[d*SRCW +: SRCW]) == r, "R2 src", int'(dstSrc[d*SRCW +: SRCW]), r);
      check(dstData[d*BEATW +: BEATW] == pl[7:0], "R2 beat0 data",
            int'(dstData[d*BEATW +: BEATW]), int'(pl[7:0]));
      check(dstLast[d] == !two, "R8 R6 last on first beat", int'(dstLast[d]), int'(!two));
      @(negedge clk);
      if (two) begin
        check(dstValid[d] && dstLast[d], "R6 second beat present", int'(dstLast[d]), 1);
        check(dstData[d*BEATW +: BEATW] == pl[15:8], "R6 beat1 data",
              int'(dstData[d*BEATW +: BEATW]), int'(pl[15:8]));
        @(negedge clk);
      end
      check(dstValid[d] == 1'b0, "R7 one packet only", int'(dstValid[d]), 0);
    end

    // R7: two destinations in parallel
    setReq(0, 0, 1'b0, 16'h0011);
    setReq(1, 1, 1'b0, 16'h0022);
    @(negedge clk); clearReq();
    @(negedge clk); @(negedge clk);
    check(dstValid == 2'b11, "R7 parallel valid", int'(dstValid), 3);
    check(dstSrc == {2'd1, 2'd0}, "R7 parallel src", int'(dstSrc), 4);
    check(dstData == {8'h22, 8'h11}, "R7 parallel data", int'(dstData), 16'h2211);
    @(negedge clk);
    check(dstValid == 2'b00, "R7 parallel done", int'(dstValid), 0);
    repeat (3) @(negedge clk);

    // R4: older higher index beats newer lower index on destination 1
    setReq(3, 1, 1'b1, 16'h3333);
    @(negedge clk); clearReq(); setReq(2, 1, 1'b0, 16'h0022);
    @(negedge clk); clearReq(); setReq(0, 1, 1'b0, 16'h0000);
    @(negedge clk); clearReq();
    check(int'(dstSrc[2 +: 2]) == 3 && dstValid[1], "R4 first beat from 3", int'(dstSrc[2 +: 2]), 3);
    @(negedge clk);
    check(int'(dstSrc[2 +: 2]) == 3 && dstLast[1], "R6 second beat from 3", int'(dstSrc[2 +: 2]), 3);
    @(negedge clk);
    check(int'(dstSrc[2 +: 2]) == 2 && dstValid[1], "R4 older request next", int'(dstSrc[2 +: 2]), 2);
    @(negedge clk);
    check(int'(dstSrc[2 +: 2]) == 0 && dstValid[1], "R4 newest last", int'(dstSrc[2 +: 2]), 0);
    repeat (4) @(negedge clk);

    // R3, R5, R6: four requestors, three two-beat packets each, to destination 0
    for (int c = 0; c < 3; c++) begin
      clearReq();
      for (int r = 0; r < NREQ; r++) setReq(r, 0, 1'b1, 16'hA000 | 16'(r << 4) | 16'(c));
      @(negedge clk);
      if (c == 1) begin
        check(reqCredit[3*NDST+0] == 1'b0, "R3 credit low when two queued",
              int'(reqCredit[3*NDST+0]), 0);
        check(reqCredit[0] == 1'b1, "R3 credit kept after grant", int'(reqCredit[0]), 1);
      end
    end
    clearReq();
    beatCnt = 0; nFirst = 0; prevOpen = 1'b0; prevSrc = 0;
    for (int k = 0; k < 24; k++) begin
      if (dstValid[0]) begin
        beatCnt++;
        if (prevOpen) begin
          check(dstLast[0] && int'(dstSrc[1:0]) == prevSrc, "R6 burst second beat",
                int'(dstSrc[1:0]), prevSrc);
          prevOpen = 1'b0;
        end else begin
          if (nFirst < 9) begin
            firstSrc[nFirst] = int'(dstSrc[1:0]);
            firstLow[nFirst] = int'(dstData[7:0]);
          end
          nFirst++;
          prevOpen = 1'b1;
          prevSrc = int'(dstSrc[1:0]);
        end
      end
      @(negedge clk);
    end
    check(beatCnt == 18, "R3 dropped requests never delivered", beatCnt, 18);
    check(nFirst == 9, "R3 packet count", nFirst, 9);
    for (int j = 0; j < 9; j++) begin
      int expR, expC;
      expR = j % 4; expC = j / 4;
      check(firstSrc[j] == expR, "R5 tie order src", firstSrc[j], expR);
      check(firstLow[j] == ((expR << 4) | expC), "R4 age order payload",
            firstLow[j], (expR << 4) | expC);
    end
    check(reqCredit == '1, "R3 credits restored", int'(reqCredit), 255);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule